// File: doc/BRIEF.md
# RMII Transmit Serializer (MAC side)

This block sits at the end of a MAC transmit path. It takes frame bytes from a byte-wide valid/ready stream and sends them as 2-bit symbols on a reduced media-independent transmit interface. It runs on one continuous 50 MHz reference clock. The block generates the preamble and the start-of-frame delimiter itself. It then sends the payload bytes, each as four symbols with the low bit pair first.

At 10 Mb/s every symbol is held for ten reference clocks. At 100 Mb/s it is held for one. The rate is sampled when a frame starts. After a frame, a minimum idle time is enforced with transmit enable low before the next frame may begin.

Back-pressure rules on the byte stream: the block asserts ready for exactly one clock per byte. That clock is the final clock of the last symbol of the byte on the wire, and only while the frame still wants another byte. A byte is taken on a clock edge where ready and valid are both high. A source that wants gap-free frames must hold valid with the next byte before that clock. If valid is low when ready is high, the frame ends after the byte currently on the wire. In idle, valid alone starts a frame, with no handshake. The first payload byte is then taken at the end of the preamble.

Top module: `rmii_tx_serializer`

## Requirements
- R1: While reset is held, and on the first clock after it is released, tx_en_o is 0, txd_o is 00 and in_ready_o is 0.
- R2: When in_valid_i is seen high in idle, tx_en_o rises after that clock edge together with the first preamble symbol. It then stays high without a break for (8 + n) x 4 x H clocks, where n is the number of payload bytes accepted and H is the hold length from R8.
- R3: The octets on the wire are 0x55 seven times, then 0xD5, then the payload bytes in order. Each octet is sent as four symbols, bits [1:0] first, then [3:2], [5:4] and [7:6]. Within a symbol, txd_o[0] carries the lower bit.
- R4: txd_o is 00 on every clock where tx_en_o is 0.
- R5: in_ready_o is high only in the last clock of the fourth symbol of an octet, and only when another payload byte is wanted. This is after the 0xD5 octet, or after a payload byte not marked last. Exactly one byte is taken per handshake.
- R6: After a byte taken with in_last_i high, tx_en_o falls on the clock that follows the final clock of that byte's last symbol.
- R7: If in_ready_o is high while in_valid_i is low, the frame ends after the octet on the wire. No further bytes are taken for that frame.
- R8: With speed_10m_i high, each symbol is held for 10 clocks (H = 10). With it low, each symbol lasts 1 clock (H = 1).
- R9: speed_10m_i is sampled only when a frame starts. A change during a frame has no effect on that frame's timing.
- R10: After a frame, tx_en_o stays low for at least 48 x H clocks (12 octet times). A source that holds in_valid_i high across that gap sees tx_en_o rise again after exactly 48 x H + 1 low clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| speed_10m_i | input | 1 | 1 selects 10 Mb/s symbol hold, 0 selects 100 Mb/s |
| in_valid_i | input | 1 | Byte stream valid |
| in_data_i | input | 8 | Byte stream data |
| in_last_i | input | 1 | Marks the final byte of a frame |
| in_ready_o | output | 1 | Byte accepted on this edge when valid is high |
| tx_en_o | output | 1 | Transmit enable on the RMII side |
| txd_o | output | 2 | Transmit symbol on the RMII side |

## Verification
tx_en_o and the first preamble symbol appear one clock after in_valid_i is seen in idle. Each symbol then changes every H clocks. in_ready_o lies in the same clock as the last cycle of an octet's final symbol, and the byte it takes shows up on txd_o in the next clock. The bench drives inputs and reads outputs on the falling edge. It decides a handshake from the ready and valid values it sees there, and it changes the data only after the rising edge that consumed it. It timestamps the rise and fall of tx_en_o with a counter of rising edges, so the frame length, the start latency and the 48 x H + 1 gap are compared as exact cycle counts rather than windows.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_e;

  localparam logic [7:0] PRE_OCTET = 8'h55;
  localparam logic [7:0] SFD_OCTET = 8'hD5;
endpackage

// File: rtl/rmii_tx_symclk.sv
module rmii_tx_symclk #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic slow_i,
  output logic sym_end_o
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hold_i || !slow_i || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sym_end_o = !hold_i && (!slow_i || cnt_q == LAST);

  AST_DIV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R8
  AST_FAST_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slow_i |=> cnt_q == '0); // R8
endmodule

// File: rtl/rmii_tx_shift.sv
module rmii_tx_shift #(
  parameter int DATA_W = 8,
  parameter int SYM_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              clear_i,
  output logic [SYM_W-1:0]  sym_o,
  output logic              sym_last_o
);
  localparam int SYMS = DATA_W / SYM_W;
  localparam int IW   = (SYMS > 1) ? $clog2(SYMS) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(SYMS - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [IW-1:0]     idx_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) begin
      shreg_q <= '0;
      idx_q   <= '0;
    end else if (load_i) begin
      shreg_q <= load_data_i;
      idx_q   <= '0;
    end else if (shift_i) begin
      shreg_q <= shreg_q >> SYM_W;
      idx_q   <= idx_q + 1'b1;
    end
  end

  assign sym_o      = shreg_q[SYM_W-1:0];
  assign sym_last_o = (idx_q == IDX_LAST);

  AST_LOAD_CLEAR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && clear_i)); // R3
  AST_LOAD_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && shift_i) |-> sym_last_o); // R3
endmodule

// File: rtl/rmii_tx_ctrl.sv
module rmii_tx_ctrl
  import rmii_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SYMS      = 4,
  parameter int PRE_BYTES = 8,
  parameter int GAP_BYTES = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              speed_10m_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  input  logic              sym_end_i,
  input  logic              sym_last_i,
  output logic              in_ready_o,
  output logic              tx_en_o,
  output logic              slow_o,
  output logic              idle_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              clear_o
);
  localparam int GAP_SYMS = GAP_BYTES * SYMS;
  localparam int PW = (PRE_BYTES > 1) ? $clog2(PRE_BYTES) : 1;
  localparam int GW = (GAP_SYMS > 1) ? $clog2(GAP_SYMS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_BYTES - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_SYMS - 1);

  tx_state_e     state_q, state_d;
  logic [PW-1:0] pre_cnt_q, pre_cnt_d;
  logic [GW-1:0] gap_cnt_q, gap_cnt_d;
  logic          txen_q, txen_d;
  logic          slow_q, slow_d;
  logic          last_q, last_d;
  logic          byte_end, want_more;

  always_comb begin
    byte_end    = sym_end_i && sym_last_i;
    want_more   = (state_q == ST_PRE && pre_cnt_q == PRE_LAST) ||
                  (state_q == ST_DATA && !last_q);
    in_ready_o  = byte_end && want_more;
    state_d     = state_q;
    pre_cnt_d   = pre_cnt_q;
    gap_cnt_d   = gap_cnt_q;
    txen_d      = txen_q;
    slow_d      = slow_q;
    last_d      = last_q;
    load_o      = 1'b0;
    load_data_o = in_data_i;
    clear_o     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid_i) begin
          state_d     = ST_PRE;
          txen_d      = 1'b1;
          pre_cnt_d   = '0;
          slow_d      = speed_10m_i;
          last_d      = 1'b0;
          load_o      = 1'b1;
          load_data_o = PRE_OCTET;
        end
      end
      ST_PRE, ST_DATA: begin
        if (byte_end) begin
          if (state_q == ST_PRE && pre_cnt_q != PRE_LAST) begin
            pre_cnt_d   = pre_cnt_q + 1'b1;
            load_o      = 1'b1;
            load_data_o = (pre_cnt_q == PRE_LAST - 1'b1) ? SFD_OCTET : PRE_OCTET;
          end else if (want_more && in_valid_i) begin
            state_d = ST_DATA;
            load_o  = 1'b1;
            last_d  = in_last_i;
          end else begin
            state_d   = ST_GAP;
            txen_d    = 1'b0;
            clear_o   = 1'b1;
            gap_cnt_d = '0;
          end
        end
      end
      ST_GAP: begin
        if (sym_end_i) begin
          if (gap_cnt_q == GAP_LAST) begin
            state_d   = ST_IDLE;
            gap_cnt_d = '0;
          end else begin
            gap_cnt_d = gap_cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pre_cnt_q <= '0;
      gap_cnt_q <= '0;
      txen_q    <= 1'b0;
      slow_q    <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      pre_cnt_q <= pre_cnt_d;
      gap_cnt_q <= gap_cnt_d;
      txen_q    <= txen_d;
      slow_q    <= slow_d;
      last_q    <= last_d;
    end
  end

  assign tx_en_o = txen_q;
  assign slow_o  = slow_q;
  assign idle_o  = (state_q == ST_IDLE);

  AST_GAP_TXEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_GAP |-> !txen_q); // R10
  AST_TXEN_RISE_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txen_q) |-> $past(state_q) == ST_IDLE); // R2
  AST_SPEED_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txen_q && $past(txen_q)) |-> $stable(slow_q)); // R9
  AST_NO_TAKE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && last_q) |-> !in_ready_o); // R6
endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer #(
  parameter int DATA_W    = 8,
  parameter int SYM_W     = 2,
  parameter int SLOW_DIV  = 10,
  parameter int PRE_BYTES = 8,
  parameter int GAP_BYTES = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              speed_10m_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              tx_en_o,
  output logic [SYM_W-1:0]  txd_o
);
  localparam int SYMS = DATA_W / SYM_W;

  logic              sym_end, sym_last, slow, idle;
  logic              load, clear;
  logic [DATA_W-1:0] load_data;

  rmii_tx_symclk #(.SLOW_DIV(SLOW_DIV)) u_symclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (idle),
    .slow_i    (slow),
    .sym_end_o (sym_end)
  );

  rmii_tx_ctrl #(
    .DATA_W(DATA_W), .SYMS(SYMS), .PRE_BYTES(PRE_BYTES), .GAP_BYTES(GAP_BYTES)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_10m_i (speed_10m_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_last_i   (in_last_i),
    .sym_end_i   (sym_end),
    .sym_last_i  (sym_last),
    .in_ready_o  (in_ready_o),
    .tx_en_o     (tx_en_o),
    .slow_o      (slow),
    .idle_o      (idle),
    .load_o      (load),
    .load_data_o (load_data),
    .clear_o     (clear)
  );

  rmii_tx_shift #(.DATA_W(DATA_W), .SYM_W(SYM_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (load_data),
    .shift_i     (sym_end && tx_en_o),
    .clear_i     (clear),
    .sym_o       (txd_o),
    .sym_last_o  (sym_last)
  );

  AST_IDLE_TXD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> txd_o == '0); // R4
  AST_READY_AT_BYTE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (tx_en_o && sym_last && sym_end)); // R5
  AST_SYMBOL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && $past(tx_en_o) && !$past(sym_end)) |-> $stable(txd_o)); // R8
endmodule

// File: tb/rmii_tx_serializer_tb_top.sv
module rmii_tx_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       speed;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       in_ready;
  logic       tx_en;
  logic [1:0] txd;

  int unsigned cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int txd_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n === 1'b1 && !tx_en && txd != 2'b00) txd_bad++;

  rmii_tx_serializer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .speed_10m_i(speed),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .in_ready_o(in_ready), .tx_en_o(tx_en), .txd_o(txd)
  );

  // {slow, flip, 6'b0, len, stop, base}
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'd0, 8'd1,  8'd1,  8'hA5},
    {1'b0, 1'b0, 6'd0, 8'd6,  8'd6,  8'h00},
    {1'b1, 1'b0, 6'd0, 8'd3,  8'd3,  8'h3C},
    {1'b0, 1'b0, 6'd0, 8'd16, 8'd16, 8'hFF},
    {1'b0, 1'b0, 6'd0, 8'd5,  8'd2,  8'h81},
    {1'b1, 1'b1, 6'd0, 8'd2,  8'd2,  8'h7E},
    {1'b0, 1'b1, 6'd0, 8'd4,  8'd4,  8'h12}
  };

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int base, input int i);
    return 8'(base + i * 37);
  endfunction

  function automatic logic [7:0] wire_octet(input int base, input int j);
    if (j < 7) return 8'h55;
    if (j == 7) return 8'hD5;
    return pay(base, j - 8);
  endfunction

  task automatic run_frame(input bit slow, input bit flip, input int len, input int stop,
                           input int base, input int exp_lat, input string tag,
                           output int s_cyc, output int e_cyc);
    logic [1:0] cap [1024];
    int n = 0, idx = 0, hs = 0, k = 0, div, t0, bad_data = 0, bad_hold = 0;
    bit done = 0, took = 0;
    div = slow ? 10 : 1;
    t0 = cyc;
    speed = slow;
    in_valid = (stop > 0);
    in_data = pay(base, 0);
    in_last = (len == 1);
    fork
      begin
        while (!done) begin
          @(negedge clk);
          k++;
          if (took) begin
            idx++;
            hs++;
            if (idx < stop) begin
              in_data = pay(base, idx);
              in_last = (idx == len - 1);
            end else begin
              in_valid = 1'b0;
              in_last = 1'b0;
            end
          end
          took = in_ready && in_valid;
          if (flip && k == 3) speed = ~speed;
        end
      end
      begin
        do @(negedge clk); while (!tx_en);
        s_cyc = cyc;
        while (tx_en) begin
          if (n < 1024) cap[n] = txd;
          n++;
          @(negedge clk);
        end
        e_cyc = cyc;
        done = 1;
      end
    join
    if (exp_lat >= 0) check({tag, " R2 start latency"}, (s_cyc - t0) == exp_lat, s_cyc - t0, exp_lat);
    check({tag, " R2 R8 frame length"}, (e_cyc - s_cyc) == (8 + stop) * 4 * div,
          e_cyc - s_cyc, (8 + stop) * 4 * div);
    if (n == (8 + stop) * 4 * div && n <= 1024) begin
      for (int c = 0; c < n; c++) if (cap[c] != cap[(c / div) * div]) bad_hold++;
      for (int j = 0; j < 8 + stop; j++) begin
        logic [7:0] got;
        for (int p = 0; p < 4; p++) got[2*p +: 2] = cap[(4 * j + p) * div];
        if (got != wire_octet(base, j)) bad_data++;
      end
    end else begin
      bad_data = 1;
      bad_hold = 1;
    end
    check({tag, " R3 octet content"}, bad_data == 0, bad_data, 0);
    check({tag, " R8 symbol hold"}, bad_hold == 0, bad_hold, 0);
    check({tag, " R5 handshakes"}, hs == stop, hs, stop);
  endtask

  initial begin
    int s1, e1, s2, e2;
    string tag;
    rst_n = 1'b0; speed = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 txen in reset", tx_en == 1'b0, tx_en, 0);
    check("R1 txd in reset", txd == 2'b00, txd, 0);
    check("R1 ready in reset", in_ready == 1'b0, in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txen after reset", tx_en == 1'b0, tx_en, 0);
    check("R1 txd after reset", txd == 2'b00, txd, 0);
    check("R1 ready after reset", in_ready == 1'b0, in_ready, 0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      e = VEC[v];
      tag = (e[15:8] < e[23:16]) ? "R7 underrun" : "R6 last";
      if (e[30]) tag = {tag, " R9 speed flip"};
      if (e[31]) tag = {tag, " R8 slow"};
      repeat (500) @(negedge clk);
      run_frame(e[31], e[30], int'(e[23:16]), int'(e[15:8]), int'(e[7:0]), 1, tag, s1, e1);
    end

    repeat (500) @(negedge clk);
    run_frame(1'b0, 1'b0, 2, 2, 8'h10, 1, "R6 b2b fast A", s1, e1);
    run_frame(1'b0, 1'b0, 3, 3, 8'h20, -1, "R6 b2b fast B", s2, e2);
    check("R10 gap fast", (s2 - e1) == 49, s2 - e1, 49);

    repeat (500) @(negedge clk);
    run_frame(1'b1, 1'b0, 1, 1, 8'h44, 1, "R8 b2b slow A", s1, e1);
    run_frame(1'b1, 1'b0, 1, 1, 8'h99, -1, "R8 b2b slow B", s2, e2);
    check("R10 gap slow", (s2 - e1) == 481, s2 - e1, 481);

    repeat (20) @(negedge clk);
    check("R4 txd zero while txen low", txd_bad == 0, txd_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule